// File: doc/BRIEF.md
# Cross-Vector Byte Permute Unit

This unit rearranges bytes between 128-bit vectors. An issued operation names three source registers (A, B and a control vector C) and one destination register in a local register file. Each of the 16 result bytes is taken from one of the 32 bytes of A followed by B. The matching control byte says which one. The result is registered, shown on `res_data` while `done` is high, and written back to the destination register at the end of that cycle.

Operations arrive over a valid/ready handshake. The control path is a two-state machine:
- `ST_IDLE`: the unit is ready. When `iss_valid` is seen, the transition *accept* reads all three sources, captures the permuted result and the destination index, and moves to `ST_WB`.
- `ST_WB`: the unit is not ready and `done` is high. The transition *retire* writes the result to the register file and returns to `ST_IDLE`.

A load port (`ld_en`, `ld_addr`, `ld_data`) fills registers with operands. It shares the single write port with write-back.

Top module: `vperm_unit`

## Requirements
- R1: For result lane i, only the low 5 bits of control byte i are used. Bit 4 (weight 16) picks the source: 0 selects A and 1 selects B. Bits 3:0 give the byte index within that source.
- R2: Lanes are numbered big-endian. Byte k of a 128-bit word occupies bits [127-8k : 120-8k], so lane 0 is the most significant byte. Selector 0 picks A byte 0, 15 picks A byte 15, 16 picks B byte 0 and 31 picks B byte 15.
- R3: Bits 7:5 of every control byte have no effect. For example, 0x1F, 0x5F, 0x9F and 0xDF all select B byte 15.
- R4: Any source byte may feed several lanes, and any source byte may feed none. A splat and a many-to-one pattern are both legal.
- R5: The destination may equal source A, B or C. All sources are read at acceptance, so the result is built from the values they held before the write-back.
- R6: An operation is accepted in a cycle where `iss_valid` and `iss_ready` are both high. `iss_ready` is low during the write-back cycle, and an issue presented then is not accepted and produces no `done`.
- R7: `done` is high for exactly one cycle, the cycle after acceptance. `res_data` carries the result in that cycle and holds it until the next acceptance.
- R8: The result is written to the destination register at the end of the `done` cycle. A load applied in an idle cycle writes `ld_data` to `ld_addr`. A load applied during the write-back cycle is dropped.
- R9: A register written in a cycle and read by an operation accepted in that same cycle yields its old value to that operation.
- R10: Reset clears every register to zero, holds `done` low and leaves the unit in `ST_IDLE` with `iss_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Unit can accept an issue |
| iss_ra | input | 5 | Register index of source A |
| iss_rb | input | 5 | Register index of source B |
| iss_rc | input | 5 | Register index of control vector C |
| iss_rd | input | 5 | Register index of destination |
| ld_en | input | 1 | Load a register with operand data |
| ld_addr | input | 5 | Register index to load |
| ld_data | input | 128 | Data to load |
| done | output | 1 | One-cycle completion pulse |
| res_data | output | 128 | Registered permute result |

## Verification
The bench builds the unit with its default parameters: 16 lanes and 32 registers. With these values every selector from 0 to 31 is meaningful, and a single control vector can reach both the A half and the B half of the source space in the same operation. The full 5-bit selector range is exercised by table patterns and by random control bytes whose top bits are also random. Small register indices are enough to set up the aliasing, same-cycle read/write and dropped-load cases.

// File: rtl/vperm_pkg.sv
package vperm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WB   = 1'b1
    } vp_state_e;
endpackage

// File: rtl/vp_regfile.sv
module vp_regfile #(
    parameter int DW    = 128,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    input  logic [AW-1:0] raddr_c,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b,
    output logic [DW-1:0] rdata_c,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    logic [DW-1:0] mem [NREGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational reads see the value before any write at this edge
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
    assign rdata_c = mem[raddr_c];
endmodule

// File: rtl/vp_xbar.sv
module vp_xbar #(
    parameter int LANES  = 16,
    localparam int DW    = LANES * 8,
    localparam int SELW  = $clog2(2 * LANES),
    localparam int IDXW  = SELW - 1
) (
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic [DW-1:0] ctrl,
    output logic [DW-1:0] result
);
    localparam logic [7:0] SMASK = 8'((1 << SELW) - 1);

    logic [7:0] a_by [LANES];
    logic [7:0] b_by [LANES];

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_unpack
            // Byte k sits at the high end for k = 0
            assign a_by[k] = src_a[DW-1-8*k -: 8];
            assign b_by[k] = src_b[DW-1-8*k -: 8];
        end

        for (genvar i = 0; i < LANES; i++) begin : g_lane
            logic [7:0]      cb;
            logic [SELW-1:0] sel;
            logic [IDXW-1:0] idx;
            assign cb  = ctrl[DW-1-8*i -: 8];
            assign sel = SELW'(cb & SMASK);
            assign idx = sel[IDXW-1:0];
            assign result[DW-1-8*i -: 8] = sel[SELW-1] ? b_by[idx] : a_by[idx];
        end
    endgenerate
endmodule

// File: rtl/vp_ctrl.sv
module vp_ctrl
    import vperm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic iss_valid,
    output logic iss_ready,
    output logic cap_en,
    output logic wb_en,
    output logic done
);
    vp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (iss_valid) state_d = ST_WB;   // accept
            ST_WB:   state_d = ST_IDLE;                // retire
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        iss_ready = 1'b0;
        cap_en    = 1'b0;
        wb_en     = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                iss_ready = 1'b1;
                cap_en    = iss_valid;
            end
            ST_WB: begin
                wb_en = 1'b1;
                done  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/vperm_unit.sv
module vperm_unit #(
    parameter int LANES = 16,
    parameter int NREGS = 32,
    localparam int DW   = LANES * 8,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    output logic          iss_ready,
    input  logic [AW-1:0] iss_ra,
    input  logic [AW-1:0] iss_rb,
    input  logic [AW-1:0] iss_rc,
    input  logic [AW-1:0] iss_rd,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    output logic          done,
    output logic [DW-1:0] res_data
);
    logic [DW-1:0] va, vb, vc, perm;
    logic [DW-1:0] res_q;
    logic [AW-1:0] rd_q;
    logic          cap_en, wb_en;
    logic          we;
    logic [AW-1:0] waddr;
    logic [DW-1:0] wdata;

    vp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid),
        .iss_ready (iss_ready),
        .cap_en    (cap_en),
        .wb_en     (wb_en),
        .done      (done)
    );

    // Write-back owns the port in its cycle; a load then is dropped
    assign we    = wb_en | ld_en;
    assign waddr = wb_en ? rd_q  : ld_addr;
    assign wdata = wb_en ? res_q : ld_data;

    vp_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_a (iss_ra),
        .raddr_b (iss_rb),
        .raddr_c (iss_rc),
        .rdata_a (va),
        .rdata_b (vb),
        .rdata_c (vc),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata)
    );

    vp_xbar #(.LANES(LANES)) u_xbar (
        .src_a  (va),
        .src_b  (vb),
        .ctrl   (vc),
        .result (perm)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            rd_q  <= '0;
        end else if (cap_en) begin
            res_q <= perm;
            rd_q  <= iss_rd;
        end
    end

    assign res_data = res_q;
endmodule

// File: rtl/vperm_unit_chk.sv
module vperm_unit_chk #(
    parameter int DW = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iss_valid,
    input logic          iss_ready,
    input logic          done,
    input logic [DW-1:0] res_data
);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    accept_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> done);

    // R6
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !iss_ready);

    // R7
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_valid && iss_ready) |=> $stable(res_data));

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_valid && iss_ready) |=> !done);
endmodule

bind vperm_unit vperm_unit_chk #(.DW(LANES * 8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .done      (done),
    .res_data  (res_data)
);

// File: tb/sim_vperm_unit.sv
`timescale 1ns/1ps
module sim_vperm_unit;
    localparam logic [127:0] VEC_A = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] VEC_B = 128'hf0e1d2c3b4a5968778695a4b3c2d1e0f;
    localparam int NTBL = 6;
    localparam logic [127:0] CTRL_TBL [NTBL] = '{
        128'h000102030405060708090a0b0c0d0e0f,  // identity of A
        128'h0f0e0d0c0b0a09080706050403020100,  // byte reverse of A
        128'h13131313131313131313131313131313,  // splat of B byte 3
        128'h00100111021203130414051506160717,  // interleave A/B
        128'hf0f1f2f3f4f5f6f7f8f9fafbfcfdfeff,  // B with top bits set
        128'h1f5f9fdf002040600f2f4f6f10305070   // endpoints, tagged
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         iss_valid = 1'b0;
    logic         iss_ready;
    logic [4:0]   iss_ra = '0, iss_rb = '0, iss_rc = '0, iss_rd = '0;
    logic         ld_en = 1'b0;
    logic [4:0]   ld_addr = '0;
    logic [127:0] ld_data = '0;
    logic         done;
    logic [127:0] res_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    vperm_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_ra(iss_ra), .iss_rb(iss_rb), .iss_rc(iss_rc), .iss_rd(iss_rd),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .done(done), .res_data(res_data)
    );

    function automatic logic [127:0] ref_perm(logic [127:0] a, logic [127:0] b,
                                               logic [127:0] c);
        logic [127:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            logic [7:0] cb = c[127-8*i -: 8];
            int k = int'(cb[3:0]);
            logic [7:0] pick = cb[4] ? b[127-8*k -: 8] : a[127-8*k -: 8];
            r[127-8*i -: 8] = pick;
        end
        return r;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(logic [4:0] addr, logic [127:0] data);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = addr; ld_data = data;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Issue, return the result seen with done and done one cycle later
    task automatic perm(logic [4:0] ra, logic [4:0] rb, logic [4:0] rc, logic [4:0] rd,
                        output logic [127:0] res, output logic d1, output logic d2);
        @(negedge clk);
        iss_valid = 1'b1; iss_ra = ra; iss_rb = rb; iss_rc = rc; iss_rd = rd;
        @(negedge clk);
        iss_valid = 1'b0;
        d1 = done; res = res_data;
        @(negedge clk);
        d2 = done;
    endtask

    initial begin
        #(4ns * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] res, exp, cv;
        logic d1, d2;

        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 done low", {127'd0, done}, 128'd0);
        check("R10 ready high", {127'd0, iss_ready}, 128'd1);
        rst_n = 1'b1;

        // R10: registers cleared, result of zero registers is zero
        perm(5'd10, 5'd11, 5'd12, 5'd13, res, d1, d2);
        check("R10 cleared regs", res, 128'd0);
        check("R7 done pulse", {126'd0, d1, d2}, 128'd2);

        load(5'd1, VEC_A);
        load(5'd2, VEC_B);

        // R1 R2 R3 R4: table walk
        for (int t = 0; t < NTBL; t++) begin
            load(5'd3, CTRL_TBL[t]);
            perm(5'd1, 5'd2, 5'd3, 5'd4, res, d1, d2);
            check($sformatf("R1 R2 R3 R4 table %0d", t), res,
                  ref_perm(VEC_A, VEC_B, CTRL_TBL[t]));
        end

        // R3: random controls with random upper bits
        for (int t = 0; t < 20; t++) begin
            cv = {$urandom, $urandom, $urandom, $urandom};
            load(5'd3, cv);
            perm(5'd1, 5'd2, 5'd3, 5'd4, res, d1, d2);
            check("R3 random ctrl", res, ref_perm(VEC_A, VEC_B, cv));
        end

        // R5: destination aliases A, result from old A; then observe write-back (R8)
        load(5'd3, CTRL_TBL[1]);
        load(5'd5, VEC_A);
        perm(5'd5, 5'd2, 5'd3, 5'd5, res, d1, d2);
        exp = ref_perm(VEC_A, VEC_B, CTRL_TBL[1]);
        check("R5 alias dest=A", res, exp);
        load(5'd3, CTRL_TBL[0]);
        perm(5'd5, 5'd2, 5'd3, 5'd6, res, d1, d2);
        check("R8 write-back visible", res, exp);

        // R9: load control in the same cycle as the issue reading it
        load(5'd7, CTRL_TBL[1]);
        @(negedge clk);
        iss_valid = 1'b1; iss_ra = 5'd1; iss_rb = 5'd2; iss_rc = 5'd7; iss_rd = 5'd8;
        ld_en = 1'b1; ld_addr = 5'd7; ld_data = CTRL_TBL[2];
        @(negedge clk);
        iss_valid = 1'b0; ld_en = 1'b0;
        check("R9 old value read", res_data, ref_perm(VEC_A, VEC_B, CTRL_TBL[1]));

        // R8 R6: load and issue during write-back are both ignored
        @(negedge clk);
        iss_valid = 1'b1; iss_ra = 5'd1; iss_rb = 5'd2; iss_rc = 5'd3; iss_rd = 5'd9;
        @(negedge clk);
        iss_valid = 1'b1; iss_rc = 5'd7;        // presented while busy
        ld_en = 1'b1; ld_addr = 5'd20; ld_data = VEC_B;
        check("R6 ready low in write-back", {127'd0, iss_ready}, 128'd0);
        @(negedge clk);
        iss_valid = 1'b0; ld_en = 1'b0;
        // Idle now; that late issue was not accepted, so no done
        check("R6 busy issue not accepted", {127'd0, done}, 128'd0);
        perm(5'd20, 5'd20, 5'd3, 5'd21, res, d1, d2);
        check("R8 dropped load", res, 128'd0);

        // R7: result held while idle
        exp = res_data;
        repeat (3) @(negedge clk);
        check("R7 result held", res_data, exp);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule